// File: doc/BRIEF.md
# Indexed Register and Memory Window

This block gives a host on a 32-bit bus indirect access to two targets through just two bus addresses. The host first writes a 32-bit pointer into the index register. It then reads or writes the data port. The top bit of the pointer picks the target:

- When the top bit is set, the remaining 31 bits address a linear, byte-addressed, little-endian memory. The access goes out on a request/acknowledge port.
- When the top bit is clear, the access is sent on to an internal 32-bit register space. That space is reached through a single-cycle register port.

Accesses may be 1, 2 or 4 bytes wide. For register targets, a narrow read takes the addressed bytes out of the 32-bit word. A narrow write merges the new bytes into the current word and keeps the other bytes.

Memory accesses are bounds-checked against the configured memory size. An out-of-range read returns zero and an out-of-range write is dropped. Neither one reaches the memory port.

Top module: `idx_window`

## Requirements
- R1: A write to the index address (IDX_ADDR) stores all 32 bits of bus_wdata, whatever bus_size is. A read of the index address returns the stored value in full.
- R2: The data port occupies the four byte addresses DATA_ADDR to DATA_ADDR+3, and all four use the index register. A read of any other address (not the index, not the data port) returns 0. A write to such an address changes nothing.
- R3: When index bit 31 is 1, a data-port access targets memory at byte address index[30:0]. The data-port byte offset (bus_addr[1:0]) plays no part in that address.
- R4: A memory access is performed only if index[30:0] + size <= MEM_BYTES. Otherwise no memory request is made, a read returns 0, a write is dropped, and the access completes in the cycle it is presented.
- R5: When index bit 31 is 0, the access goes to register word (index + bus_addr[1:0]) >> 2, starting at byte lane (index + bus_addr[1:0]) & 3.
- R6: A register read returns the bytes from the starting lane upward, right-aligned in bus_rdata. Bytes past lane 3 and bytes past the access size read as 0.
- R7: A register write replaces only the addressed byte lanes of the 32-bit word. All other lanes keep their previous contents.
- R8: bus_size encodes the access width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, and 3 is treated as 4 bytes. Memory data is little-endian and right-aligned: the byte at the lowest address sits in bits 7:0.
- R9: Index, register, out-of-range and unmapped accesses assert bus_ready in the same cycle. A memory access holds bus_ready low and keeps mem_req asserted until mem_ack.
- R10: After reset the index register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access present, held until bus_ready |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Bus byte address |
| bus_size | input | 2 | Access width code |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, right-aligned |
| bus_ready | output | 1 | Access completes at this clock edge |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | MEM_AW | Memory byte address |
| mem_size | output | 2 | Memory width code (0, 1 or 2) |
| mem_wdata | output | 32 | Memory write data, little-endian, masked to size |
| mem_ack | input | 1 | Memory completes the request |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| reg_valid | output | 1 | Register-space access this cycle |
| reg_write | output | 1 | Register access is a write |
| reg_addr | output | 30 | Register word address |
| reg_wdata | output | 32 | Merged full word to store |
| reg_rdata | input | 32 | Current word at reg_addr (combinational) |

## Verification
The bench sets MEM_BYTES to 64, the index at address 0 and the data port at address 4. Its memory model answers after a fixed two-cycle latency. The small memory puts the exact top-of-memory boundary in easy reach: the last in-range word, a read that is one byte over, and a write that is one byte over. The fixed latency lets the bench predict exactly how many stalled cycles a memory access costs. An eight-word register model is enough to cover every combination of index and byte offset across a word boundary.

// File: rtl/idx_window.sv
module idx_window #(
  parameter int BUS_AW = 14,
  parameter logic [BUS_AW-1:0] IDX_ADDR = 'h0,
  parameter logic [BUS_AW-1:0] DATA_ADDR = 'h4,
  parameter int MEM_BYTES = 4096,
  localparam int MEM_AW = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  output logic              mem_req,
  output logic              mem_write,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              reg_valid,
  output logic              reg_write,
  output logic [29:0]       reg_addr,
  output logic [31:0]       reg_wdata,
  input  logic [31:0]       reg_rdata
);
  localparam logic [32:0] MEM_LIM = 33'(MEM_BYTES);

  logic [31:0] idx_q;
  logic        hit_idx, hit_data, to_mem, in_bnd;
  logic [2:0]  nbytes;
  logic [32:0] span;
  logic [31:0] fwd, rd_ext, size_mask;
  logic [1:0]  lane;

  assign hit_idx  = bus_addr == IDX_ADDR;
  assign hit_data = bus_addr[BUS_AW-1:2] == DATA_ADDR[BUS_AW-1:2];
  assign to_mem   = hit_data & idx_q[31];
  assign nbytes   = (bus_size == 2'd0) ? 3'd1 : (bus_size == 2'd1) ? 3'd2 : 3'd4;
  assign span     = {2'b00, idx_q[30:0]} + {30'b0, nbytes};
  assign in_bnd   = span <= MEM_LIM;

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= '0;
    else if (bus_valid && bus_write && hit_idx) idx_q <= bus_wdata;
  end

  assign mem_req   = bus_valid & to_mem & in_bnd;
  assign mem_write = bus_write;
  assign mem_addr  = idx_q[MEM_AW-1:0];
  assign mem_size  = (bus_size == 2'd3) ? 2'd2 : bus_size;
  assign mem_wdata = bus_wdata & size_mask;

  assign fwd       = idx_q + {30'b0, bus_addr[1:0]};
  assign lane      = fwd[1:0];
  assign reg_valid = bus_valid & hit_data & ~idx_q[31];
  assign reg_write = bus_write;
  assign reg_addr  = fwd[31:2];

  for (genvar k = 0; k < 4; k++) begin : g_lane
    localparam logic [2:0] K = 3'(k);
    logic [2:0] src, rel;
    assign src = {1'b0, lane} + K;
    assign rel = K - {1'b0, lane};
    assign rd_ext[8*k +: 8] = (K < nbytes && !src[2]) ? reg_rdata[{src[1:0], 3'b000} +: 8] : 8'h00;
    assign reg_wdata[8*k +: 8] = (K >= {1'b0, lane} && rel < nbytes) ?
                                 bus_wdata[{rel[1:0], 3'b000} +: 8] : reg_rdata[8*k +: 8];
    assign size_mask[8*k +: 8] = {8{K < nbytes}};
  end

  assign bus_ready = mem_req ? mem_ack : 1'b1;

  always_comb begin
    bus_rdata = '0;
    if (hit_idx) bus_rdata = idx_q;
    else if (to_mem) bus_rdata = in_bnd ? (mem_rdata & size_mask) : 32'h0;
    else if (hit_data) bus_rdata = rd_ext;
  end
endmodule

module idx_window_chk #(
  parameter int MEM_BYTES = 4096,
  parameter int MEM_AW = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic [1:0]        bus_size,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              reg_valid,
  input logic              reg_write,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata
);
  logic [32:0] c_end;
  logic [3:0]  c_diff;
  assign c_end = 33'(mem_addr) + ((bus_size == 2'd0) ? 33'd1 : (bus_size == 2'd1) ? 33'd2 : 33'd4);
  for (genvar k = 0; k < 4; k++) begin : g_d
    assign c_diff[k] = reg_wdata[8*k +: 8] != reg_rdata[8*k +: 8];
  end

  assert_req_in_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> c_end <= 33'(MEM_BYTES));
  assert_stall_until_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |-> !bus_ready);
  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  assert_one_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_valid && mem_req));
  assert_keep_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && reg_write && bus_size == 2'd0 |-> $countones(c_diff) <= 1);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> !mem_req && !reg_valid);
endmodule

bind idx_window idx_window_chk #(.MEM_BYTES(MEM_BYTES), .MEM_AW(MEM_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_size(bus_size), .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .reg_valid(reg_valid), .reg_write(reg_write), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
);

// File: tb/idx_window_tb.sv
module idx_window_tb_top;
  localparam int CLK_P = 10;
  localparam int MEMB = 64;
  localparam int MAW = $clog2(MEMB);
  localparam int LAT = 2;
  localparam logic [13:0] IA = 14'h0;
  localparam logic [13:0] DA = 14'h4;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [13:0] bus_addr = '0;
  logic [1:0] bus_size = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_ready;
  logic mem_req, mem_write, mem_ack;
  logic [MAW-1:0] mem_addr;
  logic [1:0] mem_size;
  logic [31:0] mem_wdata, mem_rdata;
  logic reg_valid, reg_write;
  logic [29:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  always #(CLK_P/2) clk = ~clk;

  idx_window #(.BUS_AW(14), .IDX_ADDR(IA), .DATA_ADDR(DA), .MEM_BYTES(MEMB)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .mem_req(mem_req),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  function automatic logic [31:0] rf_init(int i);
    return {8'(i*16+3), 8'(i*16+2), 8'(i*16+1), 8'(i*16)};
  endfunction

  logic [31:0] rf [8];
  logic [7:0]  mem [MEMB];
  logic [31:0] exp_rf [8];
  logic [7:0]  exp_mem [MEMB];
  int cnt;
  int req_cycles = 0;

  assign reg_rdata = rf[reg_addr[2:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) rf[i] <= rf_init(i);
    end else if (reg_valid && reg_write) rf[reg_addr[2:0]] <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; cnt <= 0; mem_rdata <= '0;
      for (int i = 0; i < MEMB; i++) mem[i] <= 8'(i*5+7);
    end else if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (cnt == LAT) begin
        mem_ack <= 1'b1; cnt <= 0;
        for (int b = 0; b < 4; b++) begin
          if (b < (1 << mem_size)) begin
            if (mem_write) mem[(int'(mem_addr) + b) % MEMB] <= mem_wdata[8*b +: 8];
            mem_rdata[8*b +: 8] <= mem[(int'(mem_addr) + b) % MEMB];
          end else mem_rdata[8*b +: 8] <= 8'h00;
        end
      end else cnt <= cnt + 1;
    end
  end

  always @(posedge clk) if (mem_req) req_cycles++;

  int checks = 0, bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk); #(CLK_P/4);
    if (rst_n && bus_valid && bus_ready && !bus_write) begin
      if (exp_q.size() == 0) check(0, "unexpected read", bus_rdata, 0);
      else begin
        logic [31:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  int waits;
  task automatic xfer(input bit w, input logic [13:0] a, input logic [1:0] sz, input logic [31:0] d);
    bit r;
    @(negedge clk);
    bus_valid = 1; bus_write = w; bus_addr = a; bus_size = sz; bus_wdata = d;
    waits = 0;
    forever begin
      #(CLK_P/4); r = bus_ready;
      @(posedge clk);
      if (r) break;
      waits++;
      @(negedge clk);
    end
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic rd(input logic [13:0] a, input logic [1:0] sz, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    xfer(0, a, sz, 32'h0);
  endtask

  function automatic int nb(logic [1:0] sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  logic [31:0] m_idx;
  function automatic logic [31:0] reg_exp(logic [1:0] off, logic [1:0] sz);
    logic [31:0] f, w, r;
    f = m_idx + 32'(off); w = exp_rf[f[4:2]]; r = '0;
    for (int j = 0; j < 4; j++)
      if (j < nb(sz) && int'(f[1:0]) + j < 4) r[8*j +: 8] = w[8*(int'(f[1:0]) + j) +: 8];
    return r;
  endfunction

  task automatic reg_wr(input logic [1:0] off, input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] f;
    f = m_idx + 32'(off);
    for (int k = 0; k < 4; k++)
      if (k >= int'(f[1:0]) && k - int'(f[1:0]) < nb(sz))
        exp_rf[f[4:2]][8*k +: 8] = d[8*(k - int'(f[1:0])) +: 8];
    xfer(1, DA + 14'(off), sz, d);
  endtask

  function automatic logic [31:0] mem_exp(int a, logic [1:0] sz);
    logic [31:0] r;
    r = '0;
    if (a + nb(sz) <= MEMB)
      for (int j = 0; j < nb(sz); j++) r[8*j +: 8] = exp_mem[a + j];
    return r;
  endfunction

  task automatic set_idx(input logic [31:0] v);
    m_idx = v;
    xfer(1, IA, 2'd2, v);
  endtask

  initial begin
    #(CLK_P*20000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int rc;
    for (int i = 0; i < 8; i++) exp_rf[i] = rf_init(i);
    for (int i = 0; i < MEMB; i++) exp_mem[i] = 8'(i*5+7);
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(IA, 2'd2, 32'h0, "R10 index reset");
    xfer(1, IA, 2'd0, 32'h1234_5678); m_idx = 32'h1234_5678;
    rd(IA, 2'd2, 32'h1234_5678, "R1 index full write via byte size");
    check(waits == 0, "R9 index ready same cycle", waits, 0);

    xfer(1, 14'h40, 2'd2, 32'hFFFF_FFFF);
    rd(14'h40, 2'd2, 32'h0, "R2 unmapped reads zero");
    rd(IA, 2'd2, 32'h1234_5678, "R2 unmapped write leaves index");

    set_idx(32'h8);
    reg_wr(2'd0, 2'd2, 32'hDEAD_BEEF);
    rd(DA, 2'd2, reg_exp(0, 2), "R5 register word write/read");
    check(waits == 0, "R9 register ready same cycle", waits, 0);
    for (int o = 1; o < 4; o++) rd(DA + 14'(o), 2'd0, reg_exp(2'(o), 0), "R2 R6 byte at data offset");
    rd(DA + 14'd3, 2'd1, reg_exp(3, 1), "R6 halfword past lane 3");
    rd(DA + 14'd2, 2'd2, reg_exp(2, 2), "R6 word from lane 2");
    reg_wr(2'd2, 2'd0, 32'h0000_00A5);
    rd(DA, 2'd2, reg_exp(0, 2), "R7 byte deposit");
    reg_wr(2'd1, 2'd1, 32'h0000_1357);
    rd(DA, 2'd2, reg_exp(0, 2), "R7 halfword deposit");
    set_idx(32'h9);
    rd(DA, 2'd2, reg_exp(0, 2), "R5 unaligned index lane 1");
    reg_wr(2'd3, 2'd0, 32'h0000_0077);
    rd(DA + 14'd3, 2'd2, reg_exp(3, 2), "R5 index plus offset crosses word");
    set_idx(32'h0);
    for (int w = 0; w < 4; w++) begin
      m_idx = 32'(w * 4); xfer(1, IA, 2'd2, m_idx);
      rd(DA, 2'd2, exp_rf[w], "R5 R7 register sweep");
    end

    set_idx(32'h8000_0010);
    xfer(1, DA, 2'd2, 32'h4433_2211);
    for (int j = 0; j < 4; j++) exp_mem[16 + j] = 8'(32'h4433_2211 >> (8*j));
    check(waits == LAT + 1, "R9 memory write stall", waits, LAT + 1);
    rd(DA, 2'd0, 32'h11, "R8 little-endian low byte");
    check(waits == LAT + 1, "R9 memory read stall", waits, LAT + 1);
    rd(DA, 2'd3, 32'h4433_2211, "R8 size code 3 as word");
    set_idx(32'h8000_0011);
    rd(DA, 2'd0, 32'h22, "R3 R8 byte at next address");
    rd(DA + 14'd2, 2'd1, 32'h3322, "R3 data offset ignored for memory");

    set_idx(32'h8000_0000 | (MEMB - 4));
    rd(DA, 2'd2, mem_exp(MEMB - 4, 2), "R4 last in-range word");
    rc = req_cycles;
    set_idx(32'h8000_0000 | (MEMB - 3));
    rd(DA, 2'd2, 32'h0, "R4 word one byte over");
    check(waits == 0, "R4 out-of-range completes at once", waits, 0);
    set_idx(32'h8000_0000 | (MEMB - 1));
    xfer(1, DA, 2'd1, 32'h0000_BEEF);
    check(waits == 0, "R4 out-of-range write at once", waits, 0);
    set_idx(32'hFFFF_FFFF);
    rd(DA, 2'd0, 32'h0, "R4 huge index reads zero");
    check(req_cycles == rc, "R4 no memory request when out of range", req_cycles, rc);
    set_idx(32'h8000_0000 | (MEMB - 1));
    rd(DA, 2'd0, mem_exp(MEMB - 1, 0), "R4 dropped write left last byte");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule